// File: doc/BRIEF.md
# Table-Driven String Matching Engine

This block watches a byte stream, taking one byte per clock whenever the byte is marked valid, and reports which of up to N search strings has just finished in the stream. It is built as a finite automaton held entirely in tables, so a different set of strings can be installed while the chip is running, without rebuilding the logic. Each byte is first folded into a small symbol by a compacted symbol table. The current state and that symbol then select the next state from a compacted transition table. A per-state code table and a fixed decoder turn the state reached into a one-hot match vector.

Both compacted tables use displaced rows with owner marks. Every row has a base offset into a shared entry array. Each stored entry carries the identity of the row that placed it, and a miss falls back to a per-row default. All seven tables are shift-register memories joined in one serial chain. An external loader shifts a complete image through the chain, one bit per clock, while the block holds its state. Throughput does not depend on the data or on the strings.

Top module: `str_match_engine`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the automaton in state 0 and clears `match_vec` to zero.
- R2: Byte symbol lookup: for a byte with high nibble h and low nibble l, entry (symbase[h] + l) mod 2^CL of the symbol entry array is read. If its owner field (upper 4 bits) equals h, its symbol field (lower A bits) is the symbol. Otherwise symdef[h] is the symbol.
- R3: Transition lookup: for state s and symbol y, entry (stbase[s] + y) mod 2^P of the transition entry array is read. If its owner field (upper S bits) equals s, its next-state field (lower S bits) is taken. Otherwise stdef[s] is taken.
- R4: Match decode: a state whose code is 0 gives an all-zero vector. A code k from 1 to N sets only bit k-1, so code N drives the top bit.
- R5: A valid byte is consumed at each rising edge, back to back. The match vector for the state that byte leads to is visible right after that same edge.
- R6: While `byte_valid` is low (and no load runs), the state and `match_vec` do not change, whatever value `byte_in` carries.
- R7: While `load_busy` is high, every edge shifts `load_bit` one place into the chain. During that time the automaton state is held and `match_vec` reads zero.
- R8: The chain acts as one shift register. From the input side its segments are: symbase (16 x CL), symdef (16 x A), symbol entries (2^CL x (4+A)), stbase (2^S x P), stdef (2^S x S), transition entries (2^P x 2S), and codes (2^S x K). Entry i of a segment sits at bits i*W and up within that segment. The image is shifted most significant bit first, and `load_out` shows the far end, so a reload returns the old image in the same order.
- R9: A complete reload installs a new string set without reset. Later bytes are matched against the new tables only, starting from the held state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_busy | input | 1 | Serial load in progress: shift the chain and hold the automaton |
| load_bit | input | 1 | Serial table data into the chain |
| load_out | output | 1 | Serial data leaving the far end of the chain |
| byte_valid | input | 1 | A byte is present on `byte_in` this cycle |
| byte_in | input | 8 | Input stream byte |
| match_vec | output | N | One-hot flag of the string completed by the last consumed byte |

## Verification
The hardest situation to reach from the ports is an automaton that keeps a non-root state across a full run-time reload and then resumes correctly. The stimulus drives the stream into a terminal state, shifts a complete image through the chain while watching `load_out` and the forced-zero matches, and then sends the byte that can only match if the state survived. The bench also packs its tables with a displacement packer of its own. This makes both the owner-hit path and the default path occur, including a non-zero per-state default and a non-zero default symbol. Every consumed byte is compared against a dense automaton model.

// File: rtl/str_match_pkg.sv
package str_match_pkg;
    localparam int BYTE_W   = 8;
    localparam int NIB_W    = 4;
    localparam int NIB_ROWS = 1 << NIB_W;
endpackage

// File: rtl/str_shift_mem.sv
// Serially loaded memory: one long shift register with a random-access read port.
module str_shift_mem #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int TOT = DEPTH * WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             sdi,
    output logic             sdo,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [TOT-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (shift_en) bits_d = {bits_q[TOT-2:0], sdi};
    end

    always_ff @(posedge clk) begin
        bits_q <= bits_d;
    end

    assign sdo     = bits_q[TOT-1];
    assign rd_data = bits_q[int'(rd_addr)*WIDTH +: WIDTH];

    // R8: a shift captures the serial input at the near end
    p_shift_in_r8: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> bits_q[0] == $past(sdi));
    // R8: contents never move without a shift
    p_shift_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(bits_q));
endmodule

// File: rtl/str_symbol_map.sv
// Byte to symbol folding through a displaced-row table keyed by the high nibble.
module str_symbol_map
    import str_match_pkg::*;
#(
    parameter int A  = 6,
    parameter int CL = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              sdi,
    output logic              sdo,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [A-1:0]      sym_out
);
    localparam int CW  = NIB_W + A;
    localparam int NCT = 1 << CL;

    logic [NIB_W-1:0] hi_nib, lo_nib;
    logic [CL-1:0]    base_rd, ent_addr;
    logic [A-1:0]     def_rd;
    logic [CW-1:0]    ent_rd;
    logic             chain_a, chain_b;

    assign hi_nib   = byte_in[BYTE_W-1 -: NIB_W];
    assign lo_nib   = byte_in[NIB_W-1:0];
    assign ent_addr = base_rd + CL'(lo_nib);

    always_comb begin
        if (ent_rd[CW-1 -: NIB_W] == hi_nib) sym_out = ent_rd[A-1:0];
        else                                  sym_out = def_rd;
    end

    str_shift_mem #(.DEPTH(NIB_ROWS), .WIDTH(CL)) u_base (
        .clk(clk), .rst(rst), .shift_en(shift_en), .sdi(sdi), .sdo(chain_a),
        .rd_addr(hi_nib), .rd_data(base_rd));
    str_shift_mem #(.DEPTH(NIB_ROWS), .WIDTH(A)) u_def (
        .clk(clk), .rst(rst), .shift_en(shift_en), .sdi(chain_a), .sdo(chain_b),
        .rd_addr(hi_nib), .rd_data(def_rd));
    str_shift_mem #(.DEPTH(NCT), .WIDTH(CW)) u_ent (
        .clk(clk), .rst(rst), .shift_en(shift_en), .sdi(chain_b), .sdo(sdo),
        .rd_addr(ent_addr), .rd_data(ent_rd));
endmodule

// File: rtl/str_next_state.sv
// Compacted transition table: displaced rows with owner marks and per-state defaults.
module str_next_state #(
    parameter int S = 7,
    parameter int A = 6,
    parameter int P = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         sdi,
    output logic         sdo,
    input  logic [S-1:0] state_in,
    input  logic [A-1:0] sym_in,
    output logic [S-1:0] next_out
);
    localparam int NST = 1 << S;
    localparam int NTE = 1 << P;
    localparam int TW  = 2 * S;

    logic [P-1:0]  base_rd, ent_addr;
    logic [S-1:0]  def_rd;
    logic [TW-1:0] ent_rd;
    logic          chain_a, chain_b;

    assign ent_addr = base_rd + P'(sym_in);

    always_comb begin
        if (ent_rd[TW-1 -: S] == state_in) next_out = ent_rd[S-1:0];
        else                               next_out = def_rd;
    end

    str_shift_mem #(.DEPTH(NST), .WIDTH(P)) u_base (
        .clk(clk), .rst(rst), .shift_en(shift_en), .sdi(sdi), .sdo(chain_a),
        .rd_addr(state_in), .rd_data(base_rd));
    str_shift_mem #(.DEPTH(NST), .WIDTH(S)) u_def (
        .clk(clk), .rst(rst), .shift_en(shift_en), .sdi(chain_a), .sdo(chain_b),
        .rd_addr(state_in), .rd_data(def_rd));
    str_shift_mem #(.DEPTH(NTE), .WIDTH(TW)) u_ent (
        .clk(clk), .rst(rst), .shift_en(shift_en), .sdi(chain_b), .sdo(sdo),
        .rd_addr(ent_addr), .rd_data(ent_rd));
endmodule

// File: rtl/str_state_decode.sv
// Two-stage match decode: state to K-bit code (table), code to one-hot vector (logic).
module str_state_decode #(
    parameter int S = 7,
    parameter int K = 4,
    parameter int N = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         sdi,
    output logic         sdo,
    input  logic [S-1:0] state_in,
    output logic [N-1:0] match_out
);
    localparam int NST = 1 << S;

    logic [K-1:0] code_rd;

    str_shift_mem #(.DEPTH(NST), .WIDTH(K)) u_code (
        .clk(clk), .rst(rst), .shift_en(shift_en), .sdi(sdi), .sdo(sdo),
        .rd_addr(state_in), .rd_data(code_rd));

    for (genvar g = 0; g < N; g++) begin : g_bit
        assign match_out[g] = (code_rd == K'(g + 1));
    end
endmodule

// File: rtl/str_match_engine.sv
module str_match_engine
    import str_match_pkg::*;
#(
    parameter int N  = 15,
    parameter int A  = 6,
    parameter int S  = 7,
    parameter int P  = 7,
    parameter int CL = 7,
    localparam int K = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_busy,
    input  logic              load_bit,
    output logic              load_out,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [N-1:0]      match_vec
);
    typedef struct packed {
        logic [S-1:0] state;
        logic [N-1:0] match;
    } eng_t;

    eng_t         r_d, r_q;
    logic [A-1:0] sym;
    logic [S-1:0] step_state, nxt_state;
    logic [N-1:0] dec_vec;
    logic         chain_a, chain_b;

    str_symbol_map #(.A(A), .CL(CL)) u_symbol (
        .clk(clk), .rst(rst), .shift_en(load_busy), .sdi(load_bit), .sdo(chain_a),
        .byte_in(byte_in), .sym_out(sym));

    str_next_state #(.S(S), .A(A), .P(P)) u_trans (
        .clk(clk), .rst(rst), .shift_en(load_busy), .sdi(chain_a), .sdo(chain_b),
        .state_in(r_q.state), .sym_in(sym), .next_out(step_state));

    always_comb begin
        nxt_state = r_q.state;
        if (!load_busy && byte_valid) nxt_state = step_state;
    end

    str_state_decode #(.S(S), .K(K), .N(N)) u_decode (
        .clk(clk), .rst(rst), .shift_en(load_busy), .sdi(chain_b), .sdo(load_out),
        .state_in(nxt_state), .match_out(dec_vec));

    always_comb begin
        r_d       = r_q;
        r_d.state = nxt_state;
        r_d.match = load_busy ? '0 : dec_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign match_vec = r_q.match;

    // R1: reset lands in the root state with no match
    p_reset_root_r1: assert property (@(posedge clk)
        rst |=> (r_q.state == '0) && (match_vec == '0));
    // R7: a load cycle freezes the automaton and blanks the matches
    p_load_hold_r7: assert property (@(posedge clk) disable iff (rst)
        load_busy |=> (r_q.state == $past(r_q.state)) && (match_vec == '0));
    // R6: no byte, no movement
    p_idle_state_r6: assert property (@(posedge clk) disable iff (rst)
        (!byte_valid && !load_busy) |=> $stable(r_q.state));
    // R6: the flags persist while idle after a normal cycle
    p_idle_match_r6: assert property (@(posedge clk) disable iff (rst)
        (!byte_valid && !load_busy && !$past(load_busy)) |=> $stable(match_vec));
endmodule

// File: tb/tb_str_match_engine.sv
module tb_str_match_engine;
    localparam int N = 15, A = 6, S = 7, P = 7, CL = 7, K = 4;
    localparam int NS = 1 << S, NT = 1 << P, NC = 1 << CL;
    localparam int CW = 4 + A, TW = 2 * S;
    localparam int OFF_CBASE = 0;
    localparam int OFF_CDEF  = OFF_CBASE + 16 * CL;
    localparam int OFF_CTAB  = OFF_CDEF + 16 * A;
    localparam int OFF_TBASE = OFF_CTAB + NC * CW;
    localparam int OFF_TDEF  = OFF_TBASE + NS * P;
    localparam int OFF_TTAB  = OFF_TDEF + NS * S;
    localparam int OFF_CODE  = OFF_TTAB + NT * TW;
    localparam int TOT       = OFF_CODE + NS * K;

    logic clk = 0, rst = 1, load_busy = 0, load_bit = 0, byte_valid = 0;
    logic [7:0] byte_in = 8'h00;
    logic load_out;
    logic [N-1:0] match_vec;

    str_match_engine #(.N(N), .A(A), .S(S), .P(P), .CL(CL)) dut (
        .clk(clk), .rst(rst), .load_busy(load_busy), .load_bit(load_bit),
        .load_out(load_out), .byte_valid(byte_valid), .byte_in(byte_in),
        .match_vec(match_vec));

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    int cmap[256];
    int dfa[8][64];
    int codev[8];
    int mst = 0;
    int unsigned seed = 32'h1234_5678;
    logic [TOT-1:0] img = '0, img_prev = '0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] vec_of(input int c);
        vec_of = '0;
        if (c >= 1 && c <= N) vec_of[c-1] = 1'b1;
    endfunction

    task automatic clear_cfg();
        for (int i = 0; i < 256; i++) cmap[i] = 0;
        for (int s = 0; s < 8; s++) begin
            codev[s] = 0;
            for (int y = 0; y < 64; y++) dfa[s][y] = 0;
        end
    endtask

    // strings "abc" -> code 1, "bcd" -> code 2
    task automatic cfg_one();
        clear_cfg();
        cmap[8'h61] = 1; cmap[8'h62] = 2; cmap[8'h63] = 3; cmap[8'h64] = 4;
        for (int s = 0; s < 7; s++) begin
            dfa[s][1] = 1;
            dfa[s][2] = (s == 1) ? 2 : 4;
        end
        dfa[2][3] = 3; dfa[4][3] = 5; dfa[3][4] = 6; dfa[5][4] = 6;
        codev[3] = 1; codev[6] = 2;
    endtask

    // string "dd" -> code N; non-zero defaults for symbols and states
    task automatic cfg_two();
        clear_cfg();
        for (int l = 0; l < 16; l++) cmap[8'h60 + l] = 5;
        cmap[8'h64] = 4;
        for (int y = 0; y < 64; y++) begin
            dfa[0][y] = (y == 4) ? 1 : 0;
            dfa[1][y] = (y == 4) ? 2 : 0;
            dfa[2][y] = (y == 4) ? 2 : 3;
            dfa[3][y] = (y == 4) ? 1 : 0;
        end
        codev[2] = N;
    endtask

    task automatic build_image();
        bit cused[NC];
        bit tused[NT];
        img = '0;
        for (int i = 0; i < NC; i++) begin
            cused[i] = 0;
            img[OFF_CTAB + i*CW +: CW] = CW'(15 << A);
        end
        for (int i = 0; i < NT; i++) begin
            tused[i] = 0;
            img[OFF_TTAB + i*TW +: TW] = TW'(((1 << S) - 1) << S);
        end
        for (int h = 0; h < 16; h++) begin
            int def = cmap[h*16];
            int base = -1;
            for (int b = 0; b < NC && base < 0; b++) begin
                bit ok = 1;
                for (int l = 0; l < 16; l++)
                    if (cmap[h*16+l] != def && cused[(b+l) % NC]) ok = 0;
                if (ok) base = b;
            end
            for (int l = 0; l < 16; l++)
                if (cmap[h*16+l] != def) begin
                    cused[(base+l) % NC] = 1;
                    img[OFF_CTAB + ((base+l) % NC)*CW +: CW] = CW'((h << A) | cmap[h*16+l]);
                end
            img[OFF_CBASE + h*CL +: CL] = CL'(base);
            img[OFF_CDEF + h*A +: A] = A'(def);
        end
        for (int s = 0; s < 8; s++) begin
            int def = dfa[s][0];
            int base = -1;
            for (int b = 0; b < NT && base < 0; b++) begin
                bit ok = 1;
                for (int y = 0; y < 64; y++)
                    if (dfa[s][y] != def && tused[(b+y) % NT]) ok = 0;
                if (ok) base = b;
            end
            for (int y = 0; y < 64; y++)
                if (dfa[s][y] != def) begin
                    tused[(base+y) % NT] = 1;
                    img[OFF_TTAB + ((base+y) % NT)*TW +: TW] = TW'((s << S) | dfa[s][y]);
                end
            img[OFF_TBASE + s*P +: P] = P'(base);
            img[OFF_TDEF + s*S +: S] = S'(def);
            img[OFF_CODE + s*K +: K] = K'(codev[s]);
        end
    endtask

    // R7, R8: shift the image in MSB first; old image must appear at load_out
    task automatic do_load(input bit check_out);
        int out_bad = 0, zero_bad = 0;
        img_prev = img;
        build_image();
        for (int i = TOT - 1; i >= 0; i--) begin
            @(negedge clk);
            if (check_out && load_out !== img_prev[i]) out_bad++;
            if (i < TOT - 1 && match_vec !== '0) zero_bad++;
            load_busy = 1; load_bit = img[i]; byte_valid = 1; byte_in = 8'h64;
        end
        @(negedge clk);
        load_busy = 0; byte_valid = 0;
        if (match_vec !== '0) zero_bad++;
        chk(zero_bad == 0, "R7 matches blank during load", zero_bad, 0);
        if (check_out) chk(out_bad == 0, "R8 old image order at load_out", out_bad, 0);
    endtask

    task automatic send(input logic [7:0] b, input bit v, input string req);
        @(negedge clk);
        byte_in = b; byte_valid = v;
        @(posedge clk);
        #2;
        if (v) mst = dfa[mst][cmap[b]];
        chk(match_vec === vec_of(codev[mst]), req, match_vec, vec_of(codev[mst]));
    endtask

    task automatic t_reset_state();
        repeat (3) @(posedge clk);
        #2 chk(match_vec === '0, "R1 reset clears matches", match_vec, 0);
        @(negedge clk) rst = 0;
        mst = 0;
    endtask

    task automatic t_basic();
        send(8'h61, 1, "R5 a");
        send(8'h62, 1, "R5 ab no match yet");
        send(8'h63, 1, "R5 abc bit0 right after edge");
        send(8'h64, 1, "R3 abcd overlap gives bit1");
        send(8'h62, 1, "R3 b");
        send(8'h63, 1, "R3 bc");
        send(8'h64, 1, "R4 bcd code 2 sets bit1");
        send(8'h61, 1, "R4 code 0 gives zero");
    endtask

    task automatic t_idle();
        send(8'h61, 1, "R6 a");
        send(8'h62, 1, "R6 ab");
        for (int i = 0; i < 3; i++) send(8'h63, 0, "R6 invalid byte ignored");
        send(8'h63, 1, "R6 abc after gap");
        for (int i = 0; i < 3; i++) send(8'h71, 0, "R6 match held while idle");
    endtask

    task automatic t_compress();
        send(8'h61, 1, "R2 a");
        send(8'h62, 1, "R2 ab");
        send(8'h6F, 1, "R2 default symbol breaks string");
        send(8'h63, 1, "R2 c after break no match");
        send(8'h41, 1, "R2 upper case A is other");
        send(8'hE3, 1, "R2 same low nibble other row");
    endtask

    task automatic t_random();
        logic [7:0] pool[8] = '{8'h61, 8'h62, 8'h63, 8'h64, 8'h6F, 8'h00, 8'hFF, 8'h23};
        for (int i = 0; i < 400; i++) begin
            seed = seed * 1103515245 + 12345;
            send(pool[(seed >> 16) % 8], ((seed >> 8) % 5) != 0, "R5 random stream");
        end
    endtask

    task automatic t_reload_hold();
        send(8'h61, 1, "R7 a");
        send(8'h62, 1, "R7 ab");
        send(8'h63, 1, "R7 abc before reload");
        do_load(1);
        send(8'h64, 1, "R7 state kept across load, d completes bcd");
    endtask

    task automatic t_reset_mid();
        send(8'h61, 1, "R1 a");
        send(8'h62, 1, "R1 ab");
        @(negedge clk) rst = 1; byte_valid = 0;
        @(posedge clk);
        #2 chk(match_vec === '0, "R1 mid-stream reset", match_vec, 0);
        @(negedge clk) rst = 0;
        mst = 0;
        send(8'h63, 1, "R1 c from root gives nothing");
    endtask

    task automatic t_new_set();
        cfg_two();
        do_load(1);
        send(8'h61, 1, "R9 a now other");
        send(8'h64, 1, "R9 d");
        send(8'h64, 1, "R4 dd code N top bit");
        send(8'h64, 1, "R4 ddd stays matched");
        send(8'h60, 1, "R3 nonzero state default");
        send(8'h64, 1, "R3 default target then d");
        send(8'h64, 1, "R9 match again");
        send(8'h31, 1, "R9 other byte");
        send(8'h61, 1, "R9 old string abc");
        send(8'h62, 1, "R9 old string abc");
        send(8'h63, 1, "R9 old string no match");
    endtask

    initial begin
        t_reset_state();
        cfg_one();
        do_load(0);
        t_basic();
        t_idle();
        t_compress();
        t_random();
        t_reload_hold();
        t_reset_mid();
        t_new_set();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule